// File: doc/BRIEF.md
# GPIO Port Event Detector

This block watches the data-in vector of one GPIO port, one bit at a time. Each bit is set to one of three detection modes: level, rising edge, or any edge. When a bit's condition is met, a sticky status flag is latched for that bit. Software clears a flag by writing 1 to it. An event-enable mask chooses which latched flags drive a single level-sensitive interrupt line. The mask can be written directly. It also has a set alias that only turns bits on and a clear alias that only turns bits off, so software can change a few bits without a read-modify-write.

Edge detection compares the present data-in with a copy registered on the previous clock. There is no handshake on the register bus. A write takes effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`. The block has no state machine: each bit is a small piece of next-state logic around its flag, and these bits are repeated across the port by a generate loop.

Top module: `gpio_evt_top`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low. Reset also clears the registered copy of data-in that the edge logic compares against.
- R2: A bit in level mode (mode bit 0) latches its status flag on every clock edge at which its data-in bit is 1. The flag stays set after the input goes back to 0.
- R3: Writing 1 to a status bit (address 2) clears that bit. A bit written with 0 keeps its value.
- R4: In level mode, a clear written while the data-in bit is still 1 leaves the flag set, because the same edge sets it again.
- R5: In edge mode (mode bit 1) with its any-edge bit at 0, a bit sets its flag only on a 0-to-1 change compared with the previous clock. A 1-to-0 change is ignored.
- R6: In edge mode with its any-edge bit at 1, a bit sets its flag on both 0-to-1 and 1-to-0 changes.
- R7: When an edge on a bit and a clear of that bit fall on the same clock edge, the flag ends up set.
- R8: `irq` is high exactly when some status bit and its enable bit are both 1. It stays high after the input that caused the event returns to its old value.
- R9: A write to address 3 replaces the enable mask. A write to address 4 ORs the written bits into it. A write to address 5 clears the written bits. Reads of addresses 3, 4 and 5 all return the mask.
- R10: Status flags latch whatever their enable bits hold. An enable of 0 only keeps the flag from reaching `irq`.
- R11: Address map: 0 is the per-bit mode (0 = level, 1 = edge), 1 is the per-bit any-edge select, 2 is the status. Reads of addresses 6 and 7 return 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | WIDTH | Data-in vector of the port |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt: OR of status AND enable |

## Verification
The bench goes after the cases where a flag and a clear meet. A level-mode clear while the input is still high must not stick. A design that let it stick would report a quiet port while the pin is active. An edge arriving in the same cycle as its own clear must win. If the clear won instead, the event would be lost. Falling edges are driven under the rising-only setting to catch a design that ignores the any-edge select. The set and clear aliases are written over a partly filled mask to catch a design that treats them as plain writes. Flags are latched while their enables are 0, then the enables are turned on: irq must rise at that point, which a design that gates the latch on the enable would not do.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_MODE   = 3'd0,
        RA_ANYEDG = 3'd1,
        RA_FLAGS  = 3'd2,
        RA_EN     = 3'd3,
        RA_EN_SET = 3'd4,
        RA_EN_CLR = 3'd5
    } evt_addr_e;

endpackage

// File: rtl/gpio_evt_cfg.sv
module gpio_evt_cfg
    import gpio_evt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  mode_q,
    output logic [WIDTH-1:0]  anyedge_q,
    output logic [WIDTH-1:0]  en_q
);

    logic [WIDTH-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (wr) begin
            unique case (addr)
                RA_EN:     en_d = wdata;
                RA_EN_SET: en_d = en_q | wdata;
                RA_EN_CLR: en_d = en_q & ~wdata;
                default:   en_d = en_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            anyedge_q <= '0;
            en_q      <= '0;
        end else begin
            en_q <= en_d;
            if (wr && addr == RA_MODE)   mode_q    <= wdata;
            if (wr && addr == RA_ANYEDG) anyedge_q <= wdata;
        end
    end

    // R9: set alias only turns bits on
    a_r9_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == RA_EN_SET) |=> ((en_q & $past(wdata)) == $past(wdata)));

    // R9: clear alias only turns bits off
    a_r9_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == RA_EN_CLR) |=> ((en_q & $past(wdata)) == '0));

    // R9: set alias keeps the bits that were already on
    a_r9_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == RA_EN_SET) |=> ((en_q & $past(en_q)) == $past(en_q)));

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] mode_q,
    input  logic [WIDTH-1:0] anyedge_q,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] flags_q
);

    logic [WIDTH-1:0] din_prev;
    logic [WIDTH-1:0] hit;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic rise_b;
        logic fall_b;
        assign rise_b = din[b] & ~din_prev[b];
        assign fall_b = ~din[b] & din_prev[b];
        assign hit[b] = mode_q[b] ? (rise_b | (anyedge_q[b] & fall_b)) : din[b];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_prev <= '0;
            flags_q  <= '0;
        end else begin
            din_prev <= din;
            flags_q  <= (flags_q & ~clr_mask) | hit;
        end
    end

    // R2/R3: a flag that was not cleared stays set
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(flags_q & ~clr_mask)) == $past(flags_q & ~clr_mask)));

    // R4: a level-mode bit with its input high is set next cycle, whatever was cleared
    a_r4_level_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(din & ~mode_q)) == $past(din & ~mode_q)));

    // R6/R7: a falling edge under the any-edge select sets the flag, even against a clear
    a_r6_fall_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(mode_q & anyedge_q & din_prev & ~din))
                 == $past(mode_q & anyedge_q & din_prev & ~din)));

    // R5: in edge mode, a bit that was clear and saw no edge stays clear
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(mode_q & ~flags_q & ~(din ^ din_prev))) == '0));

endmodule

// File: rtl/gpio_evt_top.sv
module gpio_evt_top
    import gpio_evt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  din,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic              irq
);

    logic [WIDTH-1:0] mode_q;
    logic [WIDTH-1:0] anyedge_q;
    logic [WIDTH-1:0] en_q;
    logic [WIDTH-1:0] flags_q;
    logic [WIDTH-1:0] clr_mask;

    assign clr_mask = (bus_wr && bus_addr == RA_FLAGS) ? bus_wdata : '0;

    gpio_evt_cfg #(.WIDTH(WIDTH)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .mode_q    (mode_q),
        .anyedge_q (anyedge_q),
        .en_q      (en_q)
    );

    gpio_evt_detect #(.WIDTH(WIDTH)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .mode_q    (mode_q),
        .anyedge_q (anyedge_q),
        .clr_mask  (clr_mask),
        .flags_q   (flags_q)
    );

    always_comb begin
        unique case (bus_addr)
            RA_MODE:   bus_rdata = mode_q;
            RA_ANYEDG: bus_rdata = anyedge_q;
            RA_FLAGS:  bus_rdata = flags_q;
            RA_EN, RA_EN_SET, RA_EN_CLR: bus_rdata = en_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = |(flags_q & en_q);

    // R8: irq holds while no flag or enable was removed
    a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq) && clr_mask == '0 && !$past(bus_wr)) |-> irq);

    // R1: idle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> !irq);

endmodule

// File: tb/gpio_evt_top_bench.sv
`timescale 1ns/1ps
module gpio_evt_top_bench;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] din = '0;
    logic         bus_wr = 1'b0;
    logic [2:0]   bus_addr = 3'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [W-1:0] m_mode, m_any, m_en, m_flags, m_prev;

    always #10 clk = ~clk;

    gpio_evt_top #(.WIDTH(W)) u_gpio_evt_top (
        .clk(clk), .rst_n(rst_n), .din(din), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [W-1:0] f_hit(input logic [W-1:0] d, input logic [W-1:0] p,
                                           input logic [W-1:0] md, input logic [W-1:0] an);
        return (md & ((d & ~p) | (an & ~d & p))) | (~md & d);
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [W-1:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic all_chk(input string tag);
        rd_chk({tag, " flags"}, 3'd2, m_flags);
        rd_chk({tag, " enable"}, 3'd3, m_en);
        chk({tag, " irq"}, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, |(m_flags & m_en)});
    endtask

    // one clock: drive at low phase, update model, land on the next low phase
    task automatic cyc(input logic [W-1:0] d, input logic w, input logic [2:0] a,
                       input logic [W-1:0] wd);
        logic [W-1:0] clr, hit;
        din = d; bus_wr = w; bus_addr = a; bus_wdata = wd;
        hit = f_hit(d, m_prev, m_mode, m_any);
        clr = (w && a == 3'd2) ? wd : '0;
        @(posedge clk);
        m_flags = (m_flags & ~clr) | hit;
        m_prev = d;
        if (w) begin
            case (a)
                3'd0: m_mode = wd;
                3'd1: m_any = wd;
                3'd3: m_en = wd;
                3'd4: m_en = m_en | wd;
                3'd5: m_en = m_en & ~wd;
                default: ;
            endcase
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_mode = '0; m_any = '0; m_en = '0; m_flags = '0; m_prev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd_chk("R1 mode", 3'd0, '0);
        rd_chk("R1 anyedge", 3'd1, '0);
        all_chk("R1");
        // R2: level latch and hold
        cyc(32'h0000_00F0, 0, 3'd0, '0);
        cyc(32'h0, 0, 3'd0, '0);
        chk("R2 latched", m_flags, 32'h0000_00F0);
        all_chk("R2");
        // R3/R4: clear while one input still high
        cyc(32'h0000_0010, 1, 3'd2, 32'h0000_0030);
        all_chk("R4 reassert");
        chk("R4 value", m_flags, 32'h0000_00D0);
        cyc(32'h0, 1, 3'd2, 32'h0);
        all_chk("R3 zero write");
        cyc(32'h0, 1, 3'd2, 32'hFFFF_FFFF);
        all_chk("R3 clear all");
        // R11: unused addresses
        cyc(32'h0, 1, 3'd6, 32'hFFFF_FFFF);
        rd_chk("R11 addr6", 3'd6, '0);
        rd_chk("R11 addr7", 3'd7, '0);
        all_chk("R11");
        // R5: rising only
        cyc(32'h0, 1, 3'd0, 32'hFFFF_FFFF);
        rd_chk("R11 mode rd", 3'd0, 32'hFFFF_FFFF);
        cyc(32'h0000_0003, 0, 3'd0, '0);
        all_chk("R5 rise");
        cyc(32'h0000_0003, 1, 3'd2, 32'hFFFF_FFFF);
        cyc(32'h0, 0, 3'd0, '0);
        all_chk("R5 fall ignored");
        chk("R5 value", m_flags, '0);
        // R6: both edges
        cyc(32'h0000_0100, 1, 3'd1, 32'hFFFF_FFFF);
        cyc(32'h0000_0100, 1, 3'd2, 32'hFFFF_FFFF);
        cyc(32'h0, 0, 3'd0, '0);
        all_chk("R6 fall");
        chk("R6 value", m_flags, 32'h0000_0100);
        // R7: edge against same-cycle clear
        cyc(32'h0000_0110, 1, 3'd2, 32'h0000_0110);
        all_chk("R7 edge wins");
        chk("R7 value", m_flags, 32'h0000_0110);
        // R10/R8/R9: latch with enable 0, then enable
        all_chk("R10 no irq");
        cyc(32'h0000_0110, 1, 3'd4, 32'h0000_0100);
        all_chk("R9 set alias");
        cyc(32'h0, 1, 3'd4, 32'h8000_0000);
        all_chk("R8 hold");
        rd_chk("R9 read set addr", 3'd4, 32'h8000_0100);
        cyc(32'h0, 1, 3'd5, 32'h0000_0100);
        all_chk("R9 clr alias");
        rd_chk("R9 read clr addr", 3'd5, 32'h8000_0000);
        cyc(32'h0, 1, 3'd3, 32'h0000_0010);
        all_chk("R8 irq via enable write");
        // random mix, R2..R10
        void'($urandom(32'h1234_5EED));
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] a;
            a = 3'($urandom_range(0, 7));
            cyc($urandom, ($urandom_range(0, 2) == 0), a, $urandom & $urandom);
            all_chk("R8 random");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule